// File: doc/BRIEF.md
# Programmable Serial Port with Register Interface

This block is an asynchronous serial transmitter and receiver that sits on a small byte-wide processor bus. The bus has a chip select, one register-select line, and read and write strobes over an 8-bit bidirectional data bus. The strobe direction together with the select line picks one of four registers. Software writes a byte to the transmit holding register. The byte moves into a shift register and goes out on `txd_o`. Incoming characters on `rxd_i` are collected in a second shift register and then placed whole in the receive holding register.

The framing is set at run time through the configuration register: the bit rate, the character length, parity on or off with even or odd sense, and one or two stop bits. The receiver oversamples the line at sixteen times the bit rate. It confirms each start bit at mid-bit and records parity, framing and overrun errors in the status register.

Top module: `sio_uart`

## Requirements
- R1: While `cs_i` is low, the block ignores reads and writes. No register changes and no flag is cleared, and the block does not drive `data_io`.
- R2: With `cs_i` high, `sel_i`=0 selects the transmit holding register on write and the receive holding register on read. `sel_i`=1 selects the configuration register on write and the status register on read. A write strobe takes priority over a read strobe.
- R3: Configuration byte layout: bits 1:0 give the character length minus 5 (5 to 8 bits). Bit 2 enables parity, bit 3 selects odd parity (0 selects even), bit 4 selects two stop bits, and bits 7:5 give the rate code. The reset value is 0x03: 8 bits, no parity, one stop bit, rate code 0.
- R4: `txd_o` idles at 1. A frame is a 0 start bit, then the character bits least significant first, then the parity bit if enabled, then the stop bits at 1. Each bit lasts 16·(rate code+1)·BASE_DIV clock cycles.
- R5: With even parity, the parity bit makes the count of ones over the character and parity bit even. With odd parity, it makes that count odd.
- R6: Status bit 0 reads 1 while the transmit holding register is empty. A written byte moves to the shifter as soon as the shifter is idle. A second byte waits in the holding register, and bit 0 reads 0 until that byte starts. Each frame uses the configuration present when that frame starts.
- R7: The receiver confirms a start bit eight sixteenth-bit ticks after it sees a falling edge. If the line is back at 1 at that point, the event is dropped: no byte is delivered and no flag is set.
- R8: A received character is placed right-aligned in the receive register with its unused upper bits at 0, and status bit 1 (data ready) is set. Reading the receive register clears bit 1.
- R9: When parity is enabled and the received parity bit disagrees with the configured sense, status bit 2 is set.
- R10: When the first stop bit is sampled as 0, status bit 3 (framing error) is set.
- R11: When a character completes while data ready is still set, status bit 4 (overrun) is set and the unread byte is kept.
- R12: Reading the status register clears bits 4:2. Status bits 7:5 always read 0. After reset the status register reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| sel_i | input | 1 | Register select |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| data_io | inout | 8 | Bidirectional data bus |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |

## Verification
The assertions assume single-cycle bus strobes. They also assume that the configuration is not rewritten while a byte waits in the transmit holding register, and that `rxd_i` holds each bit for a full bit time at the configured rate. The stimulus issues every access as a one-cycle strobe with an idle cycle after it. It changes the configuration only once the pending byte has been taken by the shifter, and it drives serial frames from the same rate formula the requirements give. The reference model predicts the transmit line bit by bit for each queued frame and the status and receive values for each read.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef struct packed {
    logic [2:0] rate;
    logic       two_stop;
    logic       odd_par;
    logic       par_en;
    logic [1:0] len;
  } frame_cfg_t;

  localparam frame_cfg_t CFG_RST = '{rate: 3'd0, two_stop: 1'b0, odd_par: 1'b0,
                                     par_en: 1'b0, len: 2'd3};

  function automatic logic [3:0] char_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  function automatic logic [7:0] char_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  function automatic logic parity_of(input logic [7:0] d, input logic [1:0] len,
                                     input logic odd);
    return (^(d & char_mask(len))) ^ odd;
  endfunction

endpackage

// File: rtl/sio_tick.sv
module sio_tick #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i || cnt_q >= div_i) cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !clr_i && (cnt_q >= div_i);
endmodule

// File: rtl/sio_tx.sv
module sio_tx import sio_pkg::*; #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       len_i,
  input  logic             par_en_i,
  input  logic             odd_i,
  input  logic             two_stop_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             hold_full_i,
  input  logic [7:0]       hold_data_i,
  output logic             take_o,
  output logic             txd_o
);
  localparam int FRAME_W = 12;

  typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;

  tx_state_e          state_q;
  logic [FRAME_W-1:0] frame, sh_q;
  logic [3:0]         nbits, left_q, sub_q;
  logic [DIV_W-1:0]   div_q;
  logic               tick, txd_q;

  sio_tick #(.W(DIV_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_q == TX_IDLE),
    .div_i (div_q),
    .tick_o(tick)
  );

  // frame image, bit 0 leaves first; unused tail stays 1 (stop level)
  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(char_bits(len_i))) frame[1+i] = hold_data_i[i];
    if (par_en_i) frame[4'd1 + char_bits(len_i)] = parity_of(hold_data_i, len_i, odd_i);
    nbits = 4'd2 + char_bits(len_i) + {3'b000, par_en_i} + {3'b000, two_stop_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      sh_q    <= '1;
      left_q  <= '0;
      sub_q   <= '0;
      div_q   <= '0;
      txd_q   <= 1'b1;
    end else if (state_q == TX_IDLE) begin
      if (hold_full_i) begin
        state_q <= TX_SEND;
        txd_q   <= frame[0];
        sh_q    <= {1'b1, frame[FRAME_W-1:1]};
        left_q  <= nbits - 4'd1;
        sub_q   <= '0;
        div_q   <= div_i;
      end
    end else if (tick) begin
      sub_q <= sub_q + 4'd1;
      if (sub_q == 4'd15) begin
        if (left_q == 4'd0) begin
          state_q <= TX_IDLE;
          txd_q   <= 1'b1;
        end else begin
          txd_q  <= sh_q[0];
          sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
          left_q <= left_q - 4'd1;
        end
      end
    end
  end

  assign take_o = (state_q == TX_IDLE) && hold_full_i;
  assign txd_o  = txd_q;

  // R4
  tx_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_IDLE && !hold_full_i) |=> txd_o);
  // R4
  tx_start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !txd_o);
  // R6
  tx_rate_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_SEND) |=> $stable(div_q));
endmodule

// File: rtl/sio_rx.sv
module sio_rx import sio_pkg::*; #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       len_i,
  input  logic             par_en_i,
  input  logic             odd_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             rxd_i,
  output logic             done_o,
  output logic [7:0]       data_o,
  output logic             perr_o,
  output logic             ferr_o
);
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_e;

  rx_state_e        state_q;
  logic [1:0]       sync_q;
  logic             prev_q, rx_s, fall, tick, par_q;
  logic [3:0]       sub_q;
  logic [2:0]       cnt_q;
  logic [7:0]       sh_q, aligned;
  logic [1:0]       len_q;
  logic             par_en_q, odd_q;
  logic [DIV_W-1:0] div_q;
  logic             done_q, perr_q, ferr_q;
  logic [7:0]       data_q;

  assign rx_s    = sync_q[1];
  assign fall    = prev_q && !rx_s;
  assign aligned = sh_q >> (4'd8 - char_bits(len_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      prev_q <= sync_q[1];
    end
  end

  sio_tick #(.W(DIV_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_q == RX_IDLE),
    .div_i (div_q),
    .tick_o(tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RX_IDLE;
      sub_q    <= '0;
      cnt_q    <= '0;
      sh_q     <= '0;
      par_q    <= 1'b0;
      len_q    <= 2'd3;
      par_en_q <= 1'b0;
      odd_q    <= 1'b0;
      div_q    <= '0;
      done_q   <= 1'b0;
      perr_q   <= 1'b0;
      ferr_q   <= 1'b0;
      data_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        RX_IDLE: if (fall) begin
          state_q  <= RX_START;
          sub_q    <= '0;
          len_q    <= len_i;
          par_en_q <= par_en_i;
          odd_q    <= odd_i;
          div_q    <= div_i;
        end
        RX_START: if (tick) begin
          sub_q <= sub_q + 4'd1;
          if (sub_q == 4'd7) begin
            sub_q <= '0;
            cnt_q <= '0;
            state_q <= rx_s ? RX_IDLE : RX_DATA;  // line back high: glitch
          end
        end
        RX_DATA: if (tick) begin
          sub_q <= sub_q + 4'd1;
          if (sub_q == 4'd15) begin
            sh_q  <= {rx_s, sh_q[7:1]};
            cnt_q <= cnt_q + 3'd1;
            if ({1'b0, cnt_q} == char_bits(len_q) - 4'd1)
              state_q <= par_en_q ? RX_PAR : RX_STOP;
          end
        end
        RX_PAR: if (tick) begin
          sub_q <= sub_q + 4'd1;
          if (sub_q == 4'd15) begin
            par_q   <= rx_s;
            state_q <= RX_STOP;
          end
        end
        RX_STOP: if (tick) begin
          sub_q <= sub_q + 4'd1;
          if (sub_q == 4'd15) begin
            state_q <= RX_IDLE;
            done_q  <= 1'b1;
            data_q  <= aligned;
            ferr_q  <= !rx_s;
            perr_q  <= par_en_q && (par_q != parity_of(aligned, len_q, odd_q));
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;

  // R8
  rx_done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  rx_no_done_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START) |=> !done_o);
endmodule

// File: rtl/sio_uart.sv
module sio_uart import sio_pkg::*; #(
  parameter int BASE_DIV = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       sel_i,
  input  logic       rd_i,
  input  logic       wr_i,
  inout  wire  [7:0] data_io,
  input  logic       rxd_i,
  output logic       txd_o
);
  localparam int DIV_W = $clog2(8 * BASE_DIV + 1);

  frame_cfg_t       cfg_q;
  logic [7:0]       hold_q, rbuf_q, rd_data, wdata;
  logic             full_q, rdy_q, perr_q, ferr_q, ovr_q;
  logic             wr_tx, wr_cfg, rd_rx, rd_st, rd_en;
  logic             tx_take, rx_done, rx_perr, rx_ferr;
  logic [7:0]       rx_data;
  logic [DIV_W-1:0] div;

  assign wdata  = data_io;
  assign wr_tx  = cs_i && wr_i && !sel_i;
  assign wr_cfg = cs_i && wr_i && sel_i;
  assign rd_en  = cs_i && rd_i && !wr_i;
  assign rd_rx  = rd_en && !sel_i;
  assign rd_st  = rd_en && sel_i;
  assign div    = DIV_W'((int'(cfg_q.rate) + 1) * BASE_DIV - 1);

  assign rd_data = sel_i ? {3'b000, ovr_q, ferr_q, perr_q, rdy_q, !full_q} : rbuf_q;
  assign data_io = rd_en ? rd_data : {8{1'bz}};

  sio_tx #(.DIV_W(DIV_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .len_i      (cfg_q.len),
    .par_en_i   (cfg_q.par_en),
    .odd_i      (cfg_q.odd_par),
    .two_stop_i (cfg_q.two_stop),
    .div_i      (div),
    .hold_full_i(full_q),
    .hold_data_i(hold_q),
    .take_o     (tx_take),
    .txd_o      (txd_o)
  );

  sio_rx #(.DIV_W(DIV_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .len_i   (cfg_q.len),
    .par_en_i(cfg_q.par_en),
    .odd_i   (cfg_q.odd_par),
    .div_i   (div),
    .rxd_i   (rxd_i),
    .done_o  (rx_done),
    .data_o  (rx_data),
    .perr_o  (rx_perr),
    .ferr_o  (rx_ferr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_RST;
      hold_q <= '0;
      full_q <= 1'b0;
      rbuf_q <= '0;
      rdy_q  <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (tx_take) full_q <= 1'b0;
      if (wr_tx) begin
        hold_q <= wdata;
        full_q <= 1'b1;
      end
      if (wr_cfg) cfg_q <= frame_cfg_t'(wdata);
      if (rd_rx)  rdy_q <= 1'b0;
      if (rd_st) begin
        perr_q <= 1'b0;
        ferr_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (rx_done) begin
        if (rdy_q && !rd_rx) begin
          ovr_q <= 1'b1;
        end else begin
          rbuf_q <= rx_data;
          rdy_q  <= 1'b1;
        end
        if (rx_perr) perr_q <= 1'b1;
        if (rx_ferr) ferr_q <= 1'b1;
      end
    end
  end

  // R1
  no_cs_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> $stable(cfg_q));
  // R6
  take_needs_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_take |-> full_q);
  // R8
  rd_clears_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rx && !rx_done) |=> !rdy_q);
  // R11
  ovr_keeps_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && rdy_q && !rd_rx) |=> (ovr_q && $stable(rbuf_q)));
  // R12
  st_clears_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_st && !rx_done) |=> !(perr_q || ferr_q || ovr_q));
endmodule

// File: tb/sio_uart_bench.sv
module sio_uart_bench;
  localparam int BASE_DIV = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sel = 1'b0, rd = 1'b0, wr = 1'b0, rxd = 1'b1;
  logic txd;
  logic drv_en = 1'b0;
  logic [7:0] drv_val = 8'h00;
  wire  [7:0] bus;

  assign bus = drv_en ? drv_val : 8'bz;
  always #5 clk = ~clk;

  sio_uart #(.BASE_DIV(BASE_DIV)) u_sio_uart (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sel_i(sel), .rd_i(rd), .wr_i(wr),
    .data_io(bus), .rxd_i(rxd), .txd_o(txd)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] cfg_m = 8'h03;
  logic [7:0] rbuf_m = 8'h00;
  logic rdy_m = 1'b0, perr_m = 1'b0, ferr_m = 1'b0, ovr_m = 1'b0;
  logic [11:0] fq[$];
  int nq[$];
  int bq[$];
  logic mon_busy = 1'b0;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic int bit_time(input logic [7:0] c);
    return 16 * (int'(c[7:5]) + 1) * BASE_DIV;
  endfunction

  function automatic int nchar(input logic [7:0] c);
    return 5 + int'(c[1:0]);
  endfunction

  function automatic void build(input logic [7:0] c, input logic [7:0] d,
                                output logic [11:0] f, output int n);
    int k, ones;
    f = '1; f[0] = 1'b0; k = 1; ones = 0;
    for (int i = 0; i < nchar(c); i++) begin
      f[k] = d[i]; ones += int'(d[i]); k++;
    end
    if (c[2]) begin
      f[k] = ((ones % 2) == 1) ^ c[3]; k++;
    end
    n = k + 1 + int'(c[4]);
  endfunction

  task automatic wr_reg(input logic s, input logic [7:0] v);
    @(negedge clk); cs = 1'b1; sel = s; wr = 1'b1; drv_en = 1'b1; drv_val = v;
    @(negedge clk); cs = 1'b0; wr = 1'b0; drv_en = 1'b0;
    if (s) cfg_m = v;
  endtask

  task automatic rd_reg(input logic s, output logic [7:0] v);
    @(negedge clk); cs = 1'b1; sel = s; rd = 1'b1;
    #2 v = bus;
    @(negedge clk); cs = 1'b0; rd = 1'b0;
  endtask

  task automatic tx_send(input logic [7:0] d);
    logic [11:0] f; int n;
    build(cfg_m, d, f, n);
    fq.push_back(f); nq.push_back(n); bq.push_back(bit_time(cfg_m));
    wr_reg(1'b0, d);
  endtask

  task automatic tx_wait();
    while (fq.size() != 0 || mon_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic rx_send(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    logic [11:0] f; int n, bt;
    build(cfg_m, d, f, n);
    bt = bit_time(cfg_m);
    if (bad_par && cfg_m[2]) f[1+nchar(cfg_m)] = ~f[1+nchar(cfg_m)];
    if (bad_stop) f[n-1-int'(cfg_m[4])] = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk); rxd = f[k];
      repeat (bt - 1) @(negedge clk);
    end
    if (bad_stop) repeat (bt) @(negedge clk);
    @(negedge clk); rxd = 1'b1;
    repeat (bt) @(negedge clk);
    if (rdy_m) ovr_m = 1'b1;
    else begin
      rbuf_m = d & (8'hFF >> (3 - int'(cfg_m[1:0])));
      rdy_m  = 1'b1;
    end
    if (bad_par && cfg_m[2]) perr_m = 1'b1;
    if (bad_stop) ferr_m = 1'b1;
  endtask

  task automatic rx_check(input string req);
    logic [7:0] v;
    rd_reg(1'b1, v);
    check({req, " status"}, v, {3'b000, ovr_m, ferr_m, perr_m, rdy_m, 1'b1});
    perr_m = 1'b0; ferr_m = 1'b0; ovr_m = 1'b0;
    if (rdy_m) begin
      rd_reg(1'b0, v);
      check({req, " rx byte"}, v, rbuf_m);
      rdy_m = 1'b0;
    end
  endtask

  // transmit line reference: each queued frame compared on every clock
  initial begin : tx_monitor
    logic [11:0] fb; int n, bt;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        if (fq.size() == 0) check("R4 unexpected start", 8'h00, 8'h01);
        else begin
          fb = fq.pop_front(); n = nq.pop_front(); bt = bq.pop_front();
          mon_busy = 1'b1;
          for (int k = 0; k < n; k++)
            for (int c = 0; c < bt; c++) begin
              if (k != 0 || c != 0) @(negedge clk);
              check("R4 R5 tx line", {7'b0, txd}, {7'b0, fb[k]});
            end
          mon_busy = 1'b0;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state, R4 idle line, R3 reset config gives 8N1
    rd_reg(1'b1, v);
    check("R12 reset status", v, 8'h01);
    check("R4 idle line", {7'b0, txd}, 8'h01);

    // R2 R3 R4 default 8N1
    tx_send(8'hA5); tx_wait();
    // R3 R5 5 bits, even parity, two stops, rate 1
    wr_reg(1'b1, 8'h34); tx_send(8'h17); tx_wait();
    // R5 7 bits, odd parity
    wr_reg(1'b1, 8'h0E); tx_send(8'h41); tx_wait();

    // R6 holding register and run-time reconfiguration
    wr_reg(1'b1, 8'h03); tx_send(8'h5A);
    wr_reg(1'b1, 8'h2D); tx_send(8'h96);
    rd_reg(1'b1, v); check("R6 holding occupied", v, 8'h00);
    tx_wait();
    rd_reg(1'b1, v); check("R6 holding drained", v, 8'h01);

    // R8 receive 8N1
    wr_reg(1'b1, 8'h03); rx_send(8'h3C, 1'b0, 1'b0); rx_check("R8");
    rd_reg(1'b1, v); check("R8 ready cleared", v, 8'h01);
    // R9 parity
    wr_reg(1'b1, 8'h34); rx_send(8'h15, 1'b0, 1'b0); rx_check("R9 good parity");
    rx_send(8'h0B, 1'b1, 1'b0); rx_check("R9 bad even parity");
    rx_check("R12 errors cleared");
    wr_reg(1'b1, 8'h0E); rx_send(8'h7F, 1'b1, 1'b0); rx_check("R9 bad odd parity");
    // R10 framing
    wr_reg(1'b1, 8'h03); rx_send(8'hE7, 1'b0, 1'b1); rx_check("R10");
    // R11 overrun keeps first byte
    rx_send(8'h11, 1'b0, 1'b0); rx_send(8'h22, 1'b0, 1'b0); rx_check("R11");

    // R7 short low pulse rejected
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (48) @(negedge clk);
    rx_check("R7 glitch");

    // R1 deselected write ignored: frame still uses 8N1
    @(negedge clk); cs = 1'b0; sel = 1'b1; wr = 1'b1; drv_en = 1'b1; drv_val = 8'hFF;
    @(negedge clk); wr = 1'b0; drv_en = 1'b0;
    tx_send(8'h81); tx_wait();
    // R1 deselected read does not clear ready
    rx_send(8'h42, 1'b0, 1'b0);
    @(negedge clk); cs = 1'b0; sel = 1'b0; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    rx_check("R1 deselected read");

    summary();
    $finish;
  end
endmodule